// File: doc/BRIEF.md
# Watermarked Word Queue with Interrupt Selection

This block is a single queue of 32-bit words behind one access port. A push strobe writes a word into the queue and a pop strobe reads the oldest word from it. The block keeps a count of stored words and derives four level flags from it: empty, nearly empty, nearly full and full. Two sticky error flags record pops from an empty queue and pushes into a full one.

The nearly-empty and nearly-full limits each come from their own 3-bit code on a power-of-two scale. A 3-bit source selector picks one of eight conditions, which are the four level flags and their inverses. An enable gates that condition onto a level interrupt line. A registered interrupt-status bit captures the interrupt and holds it until software clears it.

The depth is a parameter of at least 2 and at most 64 words. Reset empties the queue and clears every flag.

Top module: `wmq_top`

## Requirements
- R1: After reset the count is 0, both error bits are 0 and the interrupt-status bit is 0. At most DEPTH words are stored at any time.
- R2: Words leave in the order they were pushed. While the queue holds a word, `pop_data_o` shows the oldest word in the same cycle, and a pop at the next clock edge removes it.
- R3: A pop while the count is 0 reads zero on `pop_data_o` and leaves the count unchanged. It sets the underflow bit, which is bit 0 of `err_o`.
- R4: A push while the count equals DEPTH drops the word and sets the overflow bit, which is bit 1 of `err_o`. If a pop arrives in the same cycle, the pop still removes a word and the push is still dropped.
- R5: A threshold code c decodes to 0 entries when c is 0, and to 2^(c-1) entries otherwise. Code 1 gives 1, code 3 gives 4 and code 7 gives 64.
- R6: The nearly-empty flag is 1 exactly when count <= decode(`ne_code_i`).
- R7: The nearly-full flag is 1 exactly when DEPTH - count <= decode(`nf_code_i`). This threshold is independent of the nearly-empty one.
- R8: `level_o` carries empty in bit 0, nearly empty in bit 1, nearly full in bit 2 and full in bit 3. Empty means count == 0 and full means count == DEPTH.
- R9: The error bits are sticky. `err_clr_i` clears both at the clock edge. A new error event in the same cycle as the clear still sets its bit.
- R10: The source codes select a condition: 0 empty, 1 nearly empty, 2 nearly full, 3 full, 4 not empty, 5 not nearly empty, 6 not nearly full, 7 not full. In every cycle `irq_o` equals the selected condition ANDed with `irq_en_i`.
- R11: `irq_stat_o` sets at the clock edge after any cycle in which `irq_o` is 1. It clears on `irq_stat_clr_i` only if `irq_o` is 0 in that cycle.
- R12: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 32 | Word to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | 32 | Oldest word, or zero when empty |
| ne_code_i | input | 3 | Nearly-empty threshold code |
| nf_code_i | input | 3 | Nearly-full threshold code |
| irq_src_i | input | 3 | Interrupt source selector |
| irq_en_i | input | 1 | Interrupt enable |
| err_clr_i | input | 1 | Clear strobe for both error bits |
| irq_stat_clr_i | input | 1 | Write-one-to-clear for interrupt status |
| level_o | output | 4 | Level flags {full, nearly full, nearly empty, empty} |
| err_o | output | 2 | Sticky errors {overflow, underflow} |
| count_o | output | CNT_W | Number of stored words |
| irq_o | output | 1 | Level interrupt |
| irq_stat_o | output | 1 | Latched interrupt status |

## Verification
The assertions assume that every input is a known value at each clock edge once reset is released. They also assume that the threshold codes stay stable inside a cycle, and that push and pop are single-cycle strobes sampled at the rising edge. The bench drives every input at the falling edge, from a single task that sets all of them on each step, so no input is ever left unknown or changed near the sampling edge. The bench also covers error events and clear strobes in the same cycle, and pushes and pops at the full and empty boundaries. These cases are legal input patterns, so the assertions must still hold through them.

// File: rtl/wmq_pkg.sv
package wmq_pkg;
    localparam int WORD_W    = 32;
    localparam int MAX_DEPTH = 64;
    localparam int THR_W     = 7;
    localparam int CMP_W     = 8;

    typedef struct packed {
        logic full;
        logic near_full;
        logic near_empty;
        logic empty;
    } level_t;

    typedef struct packed {
        logic ovf;
        logic unf;
    } err_t;

    function automatic logic [THR_W-1:0] thr_decode(input logic [2:0] code);
        if (code == 3'd0) return '0;
        return THR_W'(1) << (code - 3'd1);
    endfunction
endpackage

// File: rtl/wmq_store.sv
module wmq_store
    import wmq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_ev_o,
    output logic              unf_ev_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              is_empty, is_full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_empty = (cnt == '0);
    assign is_full  = (cnt == FULL_CNT);
    assign do_push  = push_i && !is_full;
    assign do_pop   = pop_i && !is_empty;
    assign ovf_ev_o = push_i && is_full;
    assign unf_ev_o = pop_i && is_empty;
    assign rdata_o  = is_empty ? '0 : mem[rd_ptr];
    assign count_o  = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_o <= FULL_CNT);
    a_r3_underflow_holds: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && count_o == '0) |=> (count_o == '0));
    a_r4_overflow_drops: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && count_o == FULL_CNT) |=> (count_o == FULL_CNT));
    a_r12_both_keep_count: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && count_o != '0 && count_o != FULL_CNT) |=> $stable(count_o));
endmodule

// File: rtl/wmq_flags.sv
module wmq_flags
    import wmq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_i,
    input  logic [2:0]       ne_code_i,
    input  logic [2:0]       nf_code_i,
    input  logic             ovf_ev_i,
    input  logic             unf_ev_i,
    input  logic             err_clr_i,
    output level_t           level_o,
    output err_t             err_o
);
    logic [CMP_W-1:0] used_w, free_w, ne_thr, nf_thr;
    err_t             err_q;

    assign used_w = CMP_W'(count_i);
    assign free_w = CMP_W'(DEPTH) - used_w;
    assign ne_thr = {1'b0, thr_decode(ne_code_i)};
    assign nf_thr = {1'b0, thr_decode(nf_code_i)};

    always_comb begin
        level_o.empty      = (used_w == '0);
        level_o.full       = (free_w == '0);
        level_o.near_empty = (used_w <= ne_thr);
        level_o.near_full  = (free_w <= nf_thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q.unf <= (err_q.unf && !err_clr_i) || unf_ev_i;
            err_q.ovf <= (err_q.ovf && !err_clr_i) || ovf_ev_i;
        end
    end
    assign err_o = err_q;

    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_o.unf && !err_clr_i) |=> err_o.unf);
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_o.ovf && !err_clr_i) |=> err_o.ovf);
    a_r3_unf_event_sets: assert property (@(posedge clk) disable iff (rst)
        unf_ev_i |=> err_o.unf);
endmodule

// File: rtl/wmq_irq.sv
module wmq_irq
    import wmq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  level_t level_i,
    input  logic [2:0] src_i,
    input  logic   en_i,
    input  logic   stat_clr_i,
    output logic   irq_o,
    output logic   irq_stat_o
);
    logic [7:0] cond_vec;
    logic [3:0] lvl_bits;
    logic       stat_q;

    assign lvl_bits = level_i;

    for (genvar g = 0; g < 8; g++) begin : g_cond
        if (g < 4) begin : g_pos
            assign cond_vec[g] = lvl_bits[g];
        end else begin : g_neg
            assign cond_vec[g] = !lvl_bits[g-4];
        end
    end

    assign irq_o = cond_vec[src_i] && en_i;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= 1'b0;
        else     stat_q <= (stat_q && !stat_clr_i) || irq_o;
    end
    assign irq_stat_o = stat_q;

    a_r11_stat_latches: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> irq_stat_o);
    a_r11_stat_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_i && !irq_o) |=> !irq_stat_o);
endmodule

// File: rtl/wmq_top.sv
module wmq_top
    import wmq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] pop_data_o,
    input  logic [2:0]        ne_code_i,
    input  logic [2:0]        nf_code_i,
    input  logic [2:0]        irq_src_i,
    input  logic              irq_en_i,
    input  logic              err_clr_i,
    input  logic              irq_stat_clr_i,
    output logic [3:0]        level_o,
    output logic [1:0]        err_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o,
    output logic              irq_stat_o
);
    logic   ovf_ev, unf_ev;
    level_t lvl;
    err_t   err;

    wmq_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst),
        .push_i(push_i), .wdata_i(push_data_i), .pop_i(pop_i),
        .rdata_o(pop_data_o), .count_o(count_o),
        .ovf_ev_o(ovf_ev), .unf_ev_o(unf_ev)
    );

    wmq_flags #(.DEPTH(DEPTH)) flags_i (
        .clk(clk), .rst(rst), .count_i(count_o),
        .ne_code_i(ne_code_i), .nf_code_i(nf_code_i),
        .ovf_ev_i(ovf_ev), .unf_ev_i(unf_ev), .err_clr_i(err_clr_i),
        .level_o(lvl), .err_o(err)
    );

    wmq_irq irq_i (
        .clk(clk), .rst(rst), .level_i(lvl), .src_i(irq_src_i),
        .en_i(irq_en_i), .stat_clr_i(irq_stat_clr_i),
        .irq_o(irq_o), .irq_stat_o(irq_stat_o)
    );

    assign level_o = lvl;
    assign err_o   = err;

    a_r8_empty_not_full: assert property (@(posedge clk) disable iff (rst)
        !(level_o[0] && level_o[3]));
    a_r4_full_push_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (push_i && level_o[3]) |=> err_o[1]);
endmodule

// File: tb/wmq_top_tb_top.sv
`timescale 1ns/1ps
module wmq_top_tb_top;
    localparam int D  = 8;
    localparam int CW = $clog2(D + 1);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, push, pop, en, eclr, sclr;
    logic [31:0] wdata, rdata;
    logic [2:0] nec, nfc, src;
    logic [3:0] level;
    logic [1:0] err;
    logic [CW-1:0] count;
    logic irq, stat;

    wmq_top #(.DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .push_i(push), .push_data_i(wdata), .pop_i(pop),
        .pop_data_o(rdata), .ne_code_i(nec), .nf_code_i(nfc), .irq_src_i(src),
        .irq_en_i(en), .err_clr_i(eclr), .irq_stat_clr_i(sclr),
        .level_o(level), .err_o(err), .count_o(count), .irq_o(irq), .irq_stat_o(stat)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [31:0] mq [D];
    int mh = 0, mc = 0, sn = 0;
    logic [1:0] merr = 2'b00;
    logic mstat = 1'b0;

    function automatic int thr(input int c);
        return (c == 0) ? 0 : (1 << (c - 1));
    endfunction

    task automatic check(input string r, input logic [31:0] a, input logic [31:0] e);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, a, e);
        end
    endtask

    task automatic step(input logic p, input logic q, input logic ec, input logic sc);
        logic [3:0] lv;
        logic cond, irq_e, unf, ovf;
        logic [31:0] d;
        @(negedge clk);
        d = {8'(nec), 8'(nfc), 16'(sn)};
        push = p; pop = q; wdata = d; eclr = ec; sclr = sc;
        src = 3'(sn % 8); en = sn[3];
        #1;
        lv[0] = (mc == 0);
        lv[1] = (mc <= thr(int'(nec)));
        lv[2] = ((D - mc) <= thr(int'(nfc)));
        lv[3] = (mc == D);
        cond  = (src < 4) ? lv[src[1:0]] : !lv[src[1:0]];
        irq_e = cond && en;
        check("R1 count", 32'(count), 32'(mc));
        check("R8 empty/full bits", {30'b0, level[3], level[0]}, {30'b0, lv[3], lv[0]});
        check("R6 R5 nearly empty", 32'(level[1]), 32'(lv[1]));
        check("R7 R5 nearly full", 32'(level[2]), 32'(lv[2]));
        check("R9 error bits", 32'(err), 32'(merr));
        check("R10 irq", 32'(irq), 32'(irq_e));
        check("R11 irq status", 32'(stat), 32'(mstat));
        if (q) begin
            if (mc == 0) check("R3 pop empty data", rdata, 32'h0);
            else         check("R2 pop data order", rdata, mq[mh]);
        end
        @(posedge clk);
        unf = q && (mc == 0);
        ovf = p && (mc == D);
        if (p && !ovf) mq[(mh + mc) % D] = d;
        if (q && !unf) begin mh = (mh + 1) % D; mc--; end
        if (p && !ovf) mc++;
        merr  = (ec ? 2'b00 : merr) | {ovf, unf};
        mstat = (mstat && !sc) || irq_e;
        sn++;
    endtask

    initial begin
        rst = 1'b1; push = 0; pop = 0; wdata = '0; nec = 0; nfc = 0;
        src = 0; en = 0; eclr = 0; sclr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        check("R1 reset count", 32'(count), 32'd0);
        check("R1 reset level", 32'(level), 32'h3);
        check("R1 reset errors", 32'(err), 32'd0);
        check("R1 reset status", 32'(stat), 32'd0);
        check("R3 reset empty data", rdata, 32'h0);
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                nec = 3'(a); nfc = 3'(b);
                // fill with overflow; R12 mixed op at i==3; R4 push+pop when full
                for (int i = 0; i < D + 3; i++)
                    step(1'b1, (i == 3) || (i == D + 2), (i == 0) && (b == 2), (i % 3) == 1);
                // drain with underflow; R12 mixed op at j==2
                for (int j = 0; j < D + 3; j++)
                    step(j == 2, 1'b1, (j == D + 2), (j % 4) == 0);
                step(1'b0, 1'b0, 1'b1, 1'b1);
            end
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule